// File: doc/BRIEF.md
# Bus controller frame timer

This block times the messages a serial-bus controller sends inside a repeating frame. It holds two down-counters that run at different resolutions. The message-gap countdown drops by one on every 1 µs tick. When it runs out, it gives a one-clock start strobe for the next message. The message sequencer reloads the same countdown when it carries out a delay instruction, and the countdown can also be used for minor or major frame timing. The frame counter drops by one every 100 ticks and starts from a 16-bit frame period that the host programs. With the full 16-bit range, a frame can last up to about 6.55 s.

The host reaches the block through a small register port. The frame period can be written and read back. The gap countdown and the frame count can be read but not written. A frame-start command loads the frame counter. When auto-repeat is enabled, the counter reloads itself at the end of each frame and the frame starts again. A period of zero keeps frames from starting or repeating.

Top module: `bc_frame_timer`

## Requirements
- R1: After a delay load of value V, the gap countdown drops by one on each clock with `tick_us` high. In the clock after it reaches zero, `msg_start` is high for exactly one clock. A load of 0 strobes in the clock after the load.
- R2: The gap countdown reads at host address 1 and cannot be written. A host write to address 1 leaves its value unchanged.
- R3: The frame period is a 16-bit register at host address 0 that can be written and read back. Address 2 reads the frame count, and address 3 reads zero. `host_rdata` is zero while `host_rd_en` is low.
- R4: Once it has strobed, the gap countdown stays at zero and gives no further strobe until the next delay load, whatever the ticks do.
- R5: While a frame runs, the frame count drops by one for every 100 ticks and holds between ticks. A prescaler that starts at zero with each frame produces this rate.
- R6: When the frame count reaches zero, `frame_expired` pulses for one clock in the next clock. If `auto_repeat` is high, the count reloads from the period and the frame keeps running. If it is low, the frame stops.
- R7: A frame period of zero blocks a frame start. If the period is zero when a frame ends, the frame stops even with auto-repeat on.
- R8: A delay load replaces an active countdown with the new value.
- R9: Reset clears all counters and the frame period and drives `busy` low. `busy` is high while the countdown or a frame is active.
- R10: A frame start during a running frame restarts it from the period and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-clock pulse every microsecond |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rd_en | input | 1 | Host read enable |
| host_rdata | output | 16 | Host read data, combinational |
| frame_start | input | 1 | Start or restart a frame |
| auto_repeat | input | 1 | Reload the frame at its end |
| dly_load | input | 1 | Load the gap countdown |
| dly_value | input | 16 | Countdown value in µs |
| msg_start | output | 1 | One-clock next-message strobe |
| frame_expired | output | 1 | One-clock end-of-frame strobe |
| busy | output | 1 | Countdown or frame active |

## Verification
The hardest case to reach from the ports is a frame restart that arrives part-way through a prescaler cycle. If the prescaler is not cleared, the first frame decrement comes too early, and only a precise tick count exposes this. The bench runs 150 ticks into a frame, restarts it, and then checks that the count has not dropped after 99 further ticks and has dropped after the 100th. A second hard case is a period that goes to zero while a frame is running with auto-repeat on. The bench writes zero during the frame and checks that the frame stops at its end instead of reloading.

// File: rtl/bc_frame_timer.sv
module bc_frame_timer #(
  parameter int TICK_DIV = 100,
  parameter int GAP_W    = 16,
  parameter int FRAME_W  = 16,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              host_wr_en,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              frame_start,
  input  logic              auto_repeat,
  input  logic              dly_load,
  input  logic [GAP_W-1:0]  dly_value,
  output logic              msg_start,
  output logic              frame_expired,
  output logic              busy
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [1:0] A_PERIOD = 2'd0;
  localparam logic [1:0] A_GAP    = 2'd1;
  localparam logic [1:0] A_FRAME  = 2'd2;

  logic [FRAME_W-1:0] period_q;
  logic [FRAME_W-1:0] frm_cnt;
  logic [PRE_W-1:0]   pre_cnt;
  logic               frm_run;
  logic [GAP_W-1:0]   gap_cnt;
  logic               gap_act;

  assign busy = gap_act | frm_run;

  always_comb begin
    host_rdata = '0;
    if (host_rd_en) begin
      case (host_addr)
        A_PERIOD: host_rdata = DATA_W'(period_q);
        A_GAP:    host_rdata = DATA_W'(gap_cnt);
        A_FRAME:  host_rdata = DATA_W'(frm_cnt);
        default:  host_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      period_q <= '0;
    else if (host_wr_en && host_addr == A_PERIOD)
      period_q <= host_wdata[FRAME_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      gap_act   <= 1'b0;
      msg_start <= 1'b0;
    end else begin
      msg_start <= 1'b0;
      if (dly_load) begin
        gap_cnt <= dly_value;
        gap_act <= 1'b1;
      end else if (gap_act) begin
        if (gap_cnt == '0) begin
          msg_start <= 1'b1;
          gap_act   <= 1'b0;
        end else if (tick_us) begin
          gap_cnt <= gap_cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_cnt       <= '0;
      pre_cnt       <= '0;
      frm_run       <= 1'b0;
      frame_expired <= 1'b0;
    end else begin
      frame_expired <= 1'b0;
      if (frame_start) begin
        if (period_q != '0) begin
          frm_cnt <= period_q;
          pre_cnt <= '0;
          frm_run <= 1'b1;
        end
      end else if (frm_run) begin
        if (frm_cnt == '0) begin
          frame_expired <= 1'b1;
          pre_cnt       <= '0;
          if (auto_repeat && period_q != '0)
            frm_cnt <= period_q;
          else
            frm_run <= 1'b0;
        end else if (tick_us) begin
          if (pre_cnt == PRE_LAST) begin
            pre_cnt <= '0;
            frm_cnt <= frm_cnt - 1'b1;
          end else begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_MSG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> !msg_start); // R1
  AST_GAP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_addr == A_GAP && !dly_load && !(gap_act && (tick_us || gap_cnt == '0)))
    |=> $stable(gap_cnt)); // R2
  AST_GAP_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!gap_act && !dly_load) |=> (gap_cnt == '0 && !msg_start && !gap_act)); // R4
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_run && frm_cnt != '0 && !frame_start && !tick_us) |=> $stable(frm_cnt)); // R5
  AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_run && frm_cnt == '0 && !frame_start && auto_repeat && period_q != '0)
    |=> (frame_expired && frm_run && frm_cnt == $past(period_q))); // R6
  AST_ZERO_PERIOD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && period_q == '0 && !frm_run) |=> !frm_run); // R7
  AST_DELAY_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    dly_load |=> (gap_act && gap_cnt == $past(dly_value))); // R8
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !dly_load && !frame_start) |=> !frame_expired); // R9
endmodule

// File: tb/bc_frame_timer_bench.sv
module bc_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic        host_rd_en = 1'b0;
  logic [15:0] host_rdata;
  logic        frame_start = 1'b0;
  logic        auto_repeat = 1'b0;
  logic        dly_load = 1'b0;
  logic [15:0] dly_value = '0;
  logic        msg_start, frame_expired, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bc_frame_timer u_bc_frame_timer (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd_en(host_rd_en), .host_rdata(host_rdata),
    .frame_start(frame_start), .auto_repeat(auto_repeat),
    .dly_load(dly_load), .dly_value(dly_value),
    .msg_start(msg_start), .frame_expired(frame_expired), .busy(busy)
  );

  localparam int NVEC = 5;
  localparam logic [15:0] VEC_DLY [NVEC] = '{16'd0, 16'd1, 16'd3, 16'd7, 16'd20};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    tick_us = 1'b1;
    for (int i = 0; i < n; i++) step();
    tick_us = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    host_addr = a;
    host_rd_en = 1'b1;
    #1;
    v = host_rdata;
    host_rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    step();
    host_wr_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    dly_value = v; dly_load = 1'b1;
    step();
    dly_load = 1'b0;
  endtask

  task automatic start_frame();
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    step(); step();
    chk("R9 busy at reset", busy, 0);
    chk("R9 msg at reset", msg_start, 0);
    rd(2'd1, v); chk("R9 gap at reset", v, 0);
    rd(2'd2, v); chk("R9 frame at reset", v, 0);
    rst_n = 1'b1;
    step();

    for (int k = 0; k < NVEC; k++) begin
      load(VEC_DLY[k]);
      rd(2'd1, v); chk("R1 loaded value", v, VEC_DLY[k]);
      chk("R1 busy after load", busy, 1);
      if (VEC_DLY[k] > 0) begin
        ticks(int'(VEC_DLY[k]) - 1);
        rd(2'd1, v); chk("R1 one left", v, 1);
        chk("R1 no early strobe", msg_start, 0);
        ticks(1);
        chk("R1 no strobe at zero edge", msg_start, 0);
      end
      step();
      chk("R1 strobe", msg_start, 1);
      chk("R1 idle after strobe", busy, 0);
      step();
      chk("R1 strobe one cycle", msg_start, 0);
    end

    ticks(5);
    chk("R4 no strobe while idle", msg_start, 0);
    rd(2'd1, v); chk("R4 held at zero", v, 0);

    load(16'd50);
    ticks(10);
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk("R2 write ignored", v, 40);

    ticks(5);
    load(16'd9);
    rd(2'd1, v); chk("R8 replaced", v, 9);
    ticks(9);
    step();
    chk("R8 strobe after new value", msg_start, 1);

    wr(2'd0, 16'hBEEF);
    rd(2'd0, v); chk("R3 period readback", v, 16'hBEEF);
    rd(2'd3, v); chk("R3 spare address", v, 0);
    host_addr = 2'd0; host_rd_en = 1'b0; #1;
    chk("R3 rdata gated", host_rdata, 0);

    wr(2'd0, 16'd2);
    auto_repeat = 1'b1;
    start_frame();
    rd(2'd2, v); chk("R5 frame loaded", v, 2);
    chk("R9 busy in frame", busy, 1);
    ticks(99);
    rd(2'd2, v); chk("R5 no early decrement", v, 2);
    ticks(1);
    rd(2'd2, v); chk("R5 decrement at 100", v, 1);
    ticks(100);
    rd(2'd2, v); chk("R5 count zero", v, 0);
    chk("R6 not yet expired", frame_expired, 0);
    step();
    chk("R6 expired strobe", frame_expired, 1);
    rd(2'd2, v); chk("R6 auto reload", v, 2);
    step();
    chk("R6 strobe one cycle", frame_expired, 0);
    chk("R6 still running", busy, 1);

    ticks(150);
    start_frame();
    rd(2'd2, v); chk("R10 restart value", v, 2);
    ticks(99);
    rd(2'd2, v); chk("R10 prescaler cleared", v, 2);
    ticks(1);
    rd(2'd2, v); chk("R10 decrement after restart", v, 1);

    auto_repeat = 1'b0;
    ticks(100);
    step();
    chk("R6 expire without repeat", frame_expired, 1);
    step();
    chk("R6 stopped", busy, 0);
    ticks(300);
    chk("R6 no further expiry", frame_expired, 0);

    wr(2'd0, 16'd0);
    start_frame();
    chk("R7 zero period blocks start", busy, 0);
    rd(2'd2, v); chk("R7 frame count stays", v, 0);

    wr(2'd0, 16'd1);
    auto_repeat = 1'b1;
    start_frame();
    wr(2'd0, 16'd0);
    ticks(100);
    step();
    chk("R7 final expiry", frame_expired, 1);
    step();
    chk("R7 no reload with zero period", busy, 0);

    wr(2'd0, 16'd3);
    start_frame();
    load(16'd30);
    rst_n = 1'b0;
    step();
    chk("R9 busy cleared by reset", busy, 0);
    rd(2'd0, v); chk("R9 period cleared", v, 0);
    rd(2'd1, v); chk("R9 gap cleared", v, 0);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule